// File: doc/BRIEF.md
# Task Runtime Watchdog Timers

This block bounds how long a task may run on one processor core. It holds a set of independent down-counters, two by default, each 32 bits wide, and every one of them counts on the core clock. When a task starts, the operating system writes the task's runtime budget into a counter through a small register write port. From the next cycle the counter loses one per clock. If it reaches zero before software stops or reloads it, the block sets a sticky timeout flag for that counter and sends a one-cycle trap request on that counter's own output line.

The trap lines pass through no enable or mask, and the block has no input for the interrupt-disable state. A task that has turned interrupts off therefore still cannot run past its budget. A combinational readback port returns any counter value or the flag word, so a scheduler can see at once how much budget is left and which budgets have run out. Writing zero to a counter stops it. A write-one-to-clear register acknowledges flags.

Top module: `task_budget_guard`

## Requirements
- R1: After reset every counter reads 0 and is stopped, every timeout flag is 0 and every trap line is low.
- R2: A write of a nonzero value to address i (0 to NUM_CNT-1) loads counter i with that value; from the following cycle it reads one less per clock.
- R3: A write of zero to address i stops counter i: it reads 0, stays at 0 and raises neither a trap nor a flag.
- R4: When a running counter steps from 1 to 0, trap_o[i] is high for exactly one cycle, with no enable or mask input gating it.
- R5: An expired counter stays at 0 and does not wrap, until software loads it again.
- R6: Expiry sets timeout flag i, which is read at address NUM_CNT as bit i and stays set until it is cleared.
- R7: A write to address NUM_CNT clears flag i only where data bit i is 1; zero bits have no effect, and an expiry in the same cycle as its clear leaves the flag set.
- R8: A load of counter i in the same cycle that counter i would expire wins: the counter takes the new value, and neither trap nor flag is raised.
- R9: The counters are independent: loading, stopping or expiring one changes neither the value, the trap nor the flag of another.
- R10: A read of an address above NUM_CNT returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; counters step on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: counter index, or NUM_CNT for the flag clear |
| wr_data | input | CNT_W | Load value, or clear mask for the flags |
| rd_addr | input | ADDR_W | Readback address |
| rd_data | output | CNT_W | Counter value, flag word, or zero |
| trap_o | output | NUM_CNT | One trap request line per counter, one-cycle pulse |

## Verification
The main function is tried with a table of load values and waiting times that ends before expiry, at expiry, one cycle after it, and long after it. These points separate an off-by-one in the countdown from a trap that lasts too long and from a counter that wraps. A minimal budget of 1 and a value near the top of the range test the edges of the decrementer, and a zero load tests the stop path. Directed sequences place a reload and a flag clear exactly in the expiry cycle to show which one has priority. A staggered pair of budgets on both counters shows that each counter keeps to its own trap line and flag bit.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

    // Kind of register selected by a read or write address.
    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_NONE = 2'd2
    } tbg_sel_e;

    function automatic tbg_sel_e tbg_decode(input int unsigned addr, input int unsigned num_cnt);
        if (addr < num_cnt)       return SEL_CNT;
        else if (addr == num_cnt) return SEL_FLAG;
        else                      return SEL_NONE;
    endfunction

endpackage

// File: rtl/tbg_counter.sv
module tbg_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             trap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             flag;
        logic             trap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire;

    always_comb begin
        st_d      = st_q;
        expire    = 1'b0;
        if (load_i) begin
            // a reload takes priority over an expiry in the same cycle
            st_d.cnt = load_val_i;
            st_d.run = |load_val_i;
        end else if (st_q.run) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.cnt = '0;
                st_d.run = 1'b0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        st_d.trap = expire;
        st_d.flag = (st_q.flag & ~clr_i) | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
    assign trap_o = st_q.trap;

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !load_i && st_q.cnt > CNT_W'(1)) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !load_i) |=> ($stable(st_q.cnt) && !st_q.trap));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.trap |=> !st_q.trap);

    a_r5_trap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.trap |-> (st_q.cnt == '0 && st_q.flag && !st_q.run));

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_i) |=> st_q.flag);

    a_r8_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!st_q.trap && st_q.cnt == $past(load_val_i)));

endmodule

// File: rtl/tbg_readmux.sv
module tbg_readmux #(
    parameter int CNT_W   = 32,
    parameter int NUM_CNT = 2,
    parameter int ADDR_W  = 2
) (
    input  logic [ADDR_W-1:0]  rd_addr_i,
    input  logic [CNT_W-1:0]   cnt_i [NUM_CNT],
    input  logic [NUM_CNT-1:0] flags_i,
    output logic [CNT_W-1:0]   rd_data_o
);
    import tbg_pkg::*;

    tbg_sel_e sel;

    always_comb begin
        sel       = tbg_decode(int'(rd_addr_i), NUM_CNT);
        rd_data_o = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel == SEL_CNT && rd_addr_i == ADDR_W'(i)) rd_data_o = cnt_i[i];
        end
        if (sel == SEL_FLAG) rd_data_o[NUM_CNT-1:0] = flags_i;
    end

endmodule

// File: rtl/task_budget_guard.sv
module task_budget_guard #(
    parameter int CNT_W   = 32,
    parameter int NUM_CNT = 2,
    parameter int ADDR_W  = $clog2(NUM_CNT + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    output logic [NUM_CNT-1:0] trap_o
);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_CNT);

    logic [CNT_W-1:0]   cnt_w [NUM_CNT];
    logic [NUM_CNT-1:0] flag_w;
    logic [NUM_CNT-1:0] clr_w;
    logic [NUM_CNT-1:0] load_w;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign load_w[g] = wr_en && (wr_addr == ADDR_W'(g));
        assign clr_w[g]  = wr_en && (wr_addr == FLAG_ADDR) && wr_data[g];

        tbg_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load_w[g]),
            .load_val_i (wr_data),
            .clr_i      (clr_w[g]),
            .cnt_o      (cnt_w[g]),
            .flag_o     (flag_w[g]),
            .trap_o     (trap_o[g])
        );
    end

    tbg_readmux #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_rd (
        .rd_addr_i (rd_addr),
        .cnt_i     (cnt_w),
        .flags_i   (flag_w),
        .rd_data_o (rd_data)
    );

    // R4 / R6: every trap pulse is accompanied by its flag
    a_r6_trap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((trap_o & ~flag_w) == '0));

    // R9: a write to one counter address never loads two counters
    a_r9_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_w));

endmodule

// File: tb/sim_task_budget_guard.sv
module sim_task_budget_guard;

    localparam int CNT_W   = 32;
    localparam int NUM_CNT = 2;
    localparam int ADDR_W  = $clog2(NUM_CNT + 2);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [CNT_W-1:0]   wr_data = '0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [CNT_W-1:0]   rd_data;
    logic [NUM_CNT-1:0] trap_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    task_budget_guard #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .trap_o(trap_o)
    );

    typedef struct packed {
        logic [31:0] load;
        logic [7:0]  wait_n;
        logic [31:0] exp_cnt;
        logic        exp_trap;
        logic        exp_flag;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{32'd5,          8'd2,  32'd3,          1'b0, 1'b0},
        '{32'd5,          8'd5,  32'd0,          1'b1, 1'b1},
        '{32'd5,          8'd6,  32'd0,          1'b0, 1'b1},
        '{32'd1,          8'd1,  32'd0,          1'b1, 1'b1},
        '{32'd0,          8'd3,  32'd0,          1'b0, 1'b0},
        '{32'hFFFF_FFF0,  8'd10, 32'hFFFF_FFE6,  1'b0, 1'b0},
        '{32'd3,          8'd10, 32'd0,          1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; returns at the next falling edge with the write taken
    task automatic reg_write(input int addr, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic reg_read(input int addr, output logic [31:0] val);
        rd_addr = ADDR_W'(addr);
        #1;
        val = rd_data;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        reg_read(0, v); check("R1 cnt0", v, 0);
        reg_read(1, v); check("R1 cnt1", v, 0);
        reg_read(2, v); check("R1 flags", v, 0);
        check("R1 trap", 32'(trap_o), 0);
        rst_n = 1'b1;
        wait_n(3);
        reg_read(0, v); check("R1 idle after reset", v, 0);

        // vector table on counter 0 (R2, R3, R4, R5, R6)
        for (int n = 0; n < NVEC; n++) begin
            reg_write(2, 32'h3);
            reg_write(0, VEC[n].load);
            wait_n(int'(VEC[n].wait_n));
            reg_read(0, v); check($sformatf("R2/R5 vec%0d cnt", n), v, VEC[n].exp_cnt);
            check($sformatf("R4 vec%0d trap", n), 32'(trap_o[0]), 32'(VEC[n].exp_trap));
            reg_read(2, v); check($sformatf("R6 vec%0d flag", n), 32'(v[0]), 32'(VEC[n].exp_flag));
        end

        // R3: stop a running counter
        reg_write(2, 32'h3);
        reg_write(0, 32'd10);
        wait_n(3);
        reg_write(0, 32'd0);
        wait_n(15);
        reg_read(0, v); check("R3 stopped value", v, 0);
        reg_read(2, v); check("R3 no flag", v, 0);
        check("R3 no trap", 32'(trap_o), 0);

        // R8: reload in the expiry cycle
        reg_write(0, 32'd3);
        wait_n(2);
        reg_write(0, 32'd7);
        check("R8 no trap", 32'(trap_o), 0);
        reg_read(0, v); check("R8 new value", v, 7);
        reg_read(2, v); check("R8 no flag", v, 0);
        wait_n(7);
        check("R4 trap after reload", 32'(trap_o), 1);
        reg_write(2, 32'h3);

        // R7: clear in the expiry cycle loses to the expiry
        reg_write(0, 32'd2);
        wait_n(1);
        reg_write(2, 32'h1);
        reg_read(2, v); check("R7 set wins over clear", v, 1);
        check("R7 trap present", 32'(trap_o), 1);
        reg_write(2, 32'h1);
        reg_read(2, v); check("R7 clear", v, 0);

        // R9: staggered budgets on both counters
        reg_write(0, 32'd4);
        reg_write(1, 32'd8);
        wait_n(3);
        check("R9 trap0 only", 32'(trap_o), 32'h1);
        reg_read(1, v); check("R9 cnt1 unaffected", v, 5);
        wait_n(5);
        check("R9 trap1 only", 32'(trap_o), 32'h2);
        reg_read(2, v); check("R9 both flags", v, 3);

        // R7: zero bits ignored, one bit clears only its flag
        reg_write(2, 32'h0);
        reg_read(2, v); check("R7 zero mask ignored", v, 3);
        reg_write(2, 32'h1);
        reg_read(2, v); check("R7 clear bit0 only", v, 2);

        // R5: expired counters remain at zero
        wait_n(20);
        reg_read(0, v); check("R5 no wrap cnt0", v, 0);
        reg_read(1, v); check("R5 no wrap cnt1", v, 0);

        // R10: unmapped address
        reg_read(3, v); check("R10 unmapped read", v, 0);

        summary();
    end

endmodule